// File: doc/BRIEF.md
# Receive Byte Queue with Trigger-Level Interrupt

This block buffers bytes arriving from a serial receiver until a processor collects them. The receiver offers one byte per cycle on a write strobe. The processor takes bytes through one read port, and each read returns and removes the oldest stored byte. The storage itself cannot be addressed. A 4-bit occupancy count is always visible, so software can see how many bytes are waiting.

Software sets a trigger level. The block emits a one-cycle receive interrupt whenever an accepted byte raises the occupancy to exactly that level. It fires again each time later writes bring the occupancy back up to the level after reads have lowered it.

When a byte arrives while all eight slots are held, the block does not drop it. The new byte replaces the most recently stored one. Both the receive and error interrupts pulse, and a sticky overrun flag is set. A dedicated strobe clears the flag. A synchronous flush empties the queue but leaves the overrun flag untouched.

Top module: `rx_fifo_thr`

## Requirements
- R1: After reset, `fill_o` is 0, `rd_data_o` is 0x00, and `rx_irq_o`, `err_irq_o` and `ovf_o` are all low.
- R2: A read while bytes are held presents the oldest byte on `rd_data_o` from the cycle after the read strobe, and removes that byte, so successive reads return bytes in arrival order.
- R3: `fill_o` is the plain binary count of held bytes, from 0000b (empty) to 1000b (eight bytes, full), updated in the cycle after each strobe.
- R4: With `trig_lvl_i` in 1..8, a write that is accepted without a read in the same cycle, and that raises the count to `trig_lvl_i`, makes `rx_irq_o` high for exactly the following cycle.
- R5: Once reads bring the count below the trigger level, later writes that raise it back to the level pulse `rx_irq_o` again.
- R6: A write while full and without a read pulses `rx_irq_o` and `err_irq_o` together for one cycle, sets `ovf_o`, and leaves `fill_o` at 1000b.
- R7: On overrun the incoming byte replaces the most recently stored byte. The older bytes keep their order, and the new byte is read last.
- R8: `ovf_o` stays high until a cycle with `ovf_clr_i` high, and goes low in the cycle after it. If an overrun coincides with the clear, the flag stays set.
- R9: A write and a read in the same cycle on a non-empty queue leave `fill_o` unchanged and raise no interrupt.
- R10: A read while empty leaves `rd_data_o` at the last byte read and `fill_o` at 0.
- R11: `flush_i` empties the queue (`fill_o` is 0 next cycle) and has priority over a write or read in the same cycle. `ovf_o` is not changed by it.
- R12: With `trig_lvl_i` at 0 or above 8, no write raises `rx_irq_o`. Only an overrun does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Byte offered by the receiver |
| wr_data_i | input | 8 | Received byte |
| rd_i | input | 1 | Processor read of the receive-buffer register |
| rd_data_o | output | 8 | Byte returned by the last effective read |
| flush_i | input | 1 | Synchronous empty request |
| ovf_clr_i | input | 1 | Clears the overrun flag |
| trig_lvl_i | input | 4 | Receive interrupt trigger level |
| fill_o | output | 4 | Number of bytes held |
| rx_irq_o | output | 1 | One-cycle receive interrupt |
| err_irq_o | output | 1 | One-cycle error (overrun) interrupt |
| ovf_o | output | 1 | Sticky overrun flag |

## Verification
Two kinds of internal fault show at the ports. A corrupt read or write pointer appears as a byte out of order, and the scoreboard catches it on the very next read that reaches the bad slot. A corrupt occupancy count appears at `fill_o` one cycle after the strobe. It also shifts the interrupt cycle away from the write that should reach the trigger level, so the per-cycle checks of the pulses expose it. An overrun that writes to the wrong slot stays hidden until the queue is drained, where the last byte read differs from the byte written during the overrun.

// File: rtl/rx_fifo_pkg.sv
package rx_fifo_pkg;
  localparam int unsigned DEPTH = 8;
  localparam int unsigned DW    = 8;
  localparam int unsigned PW    = $clog2(DEPTH);
  localparam int unsigned LW    = $clog2(DEPTH) + 1;
endpackage

// File: rtl/rx_fifo_store.sv
module rx_fifo_store #(
  parameter int unsigned DEPTH = rx_fifo_pkg::DEPTH,
  parameter int unsigned DW    = rx_fifo_pkg::DW,
  localparam int unsigned PW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [PW-1:0] wa_i,
  input  logic [DW-1:0] wd_i,
  input  logic          re_i,
  input  logic [PW-1:0] ra_i,
  output logic [DW-1:0] rd_o
);
  logic [DW-1:0] mem_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              mem_q[g] <= '0;
      else if (we_i && wa_i == PW'(g))         mem_q[g] <= wd_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rd_o <= '0;
    else if (re_i) rd_o <= mem_q[ra_i];
  end

  // R10
  rd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !re_i |=> $stable(rd_o));
endmodule

// File: rtl/rx_fifo_ctrl.sv
module rx_fifo_ctrl #(
  parameter int unsigned DEPTH = rx_fifo_pkg::DEPTH,
  localparam int unsigned PW   = $clog2(DEPTH),
  localparam int unsigned LW   = $clog2(DEPTH) + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic          rd_i,
  input  logic          flush_i,
  input  logic          ovf_clr_i,
  input  logic [3:0]    trig_lvl_i,
  output logic          we_o,
  output logic [PW-1:0] wa_o,
  output logic          re_o,
  output logic [PW-1:0] ra_o,
  output logic [LW-1:0] fill_o,
  output logic          rx_irq_o,
  output logic          err_irq_o,
  output logic          ovf_o
);
  logic [PW-1:0] wp_q, rp_q;
  logic [LW-1:0] cnt_q, cnt_d;
  logic full, empty, push, pop, ovr, trig_ok, hit;

  assign full  = (cnt_q == LW'(DEPTH));
  assign empty = (cnt_q == '0);
  assign pop   = rd_i && !empty && !flush_i;
  assign push  = wr_i && !flush_i && (!full || rd_i);
  assign ovr   = wr_i && !flush_i && full && !rd_i;

  always_comb begin
    cnt_d = cnt_q;
    if (push && !pop)      cnt_d = cnt_q + 1'b1;
    else if (pop && !push) cnt_d = cnt_q - 1'b1;
  end

  assign trig_ok = (trig_lvl_i != '0) && ({{(LW > 4 ? LW-4 : 0){1'b0}}, trig_lvl_i} <= LW'(DEPTH));
  assign hit     = push && !pop && trig_ok && (cnt_d == LW'(trig_lvl_i));

  // overrun rewrites the slot written last
  assign we_o = push || ovr;
  assign wa_o = ovr ? wp_q - 1'b1 : wp_q;
  assign re_o = pop;
  assign ra_o = rp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q <= '0; rp_q <= '0; cnt_q <= '0;
      rx_irq_o <= 1'b0; err_irq_o <= 1'b0; ovf_o <= 1'b0;
    end else begin
      rx_irq_o  <= hit || ovr;
      err_irq_o <= ovr;
      if (ovr)            ovf_o <= 1'b1;
      else if (ovf_clr_i) ovf_o <= 1'b0;
      if (flush_i) begin
        wp_q <= '0; rp_q <= '0; cnt_q <= '0;
      end else begin
        if (push) wp_q <= wp_q + 1'b1;
        if (pop)  rp_q <= rp_q + 1'b1;
        cnt_q <= cnt_d;
      end
    end
  end

  assign fill_o = cnt_q;

  // R3
  fill_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LW'(DEPTH));
  // R6
  err_pair_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_irq_o |-> (rx_irq_o && ovf_o && full));
  // R9
  rw_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && rd_i && !flush_i && !empty) |=> ($stable(cnt_q) && !rx_irq_o));
  // R10
  empty_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !wr_i && !flush_i && empty) |=> (cnt_q == '0));
  // R11
  flush_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flush_i && !ovf_clr_i) |=> (cnt_q == '0 && ovf_o == $past(ovf_o)));
  // R8
  ovf_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_o && !ovf_clr_i) |=> ovf_o);
endmodule

// File: rtl/rx_fifo_thr.sv
module rx_fifo_thr #(
  parameter int unsigned DEPTH = rx_fifo_pkg::DEPTH,
  parameter int unsigned DW    = rx_fifo_pkg::DW,
  localparam int unsigned PW   = $clog2(DEPTH),
  localparam int unsigned LW   = $clog2(DEPTH) + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          rd_i,
  output logic [DW-1:0] rd_data_o,
  input  logic          flush_i,
  input  logic          ovf_clr_i,
  input  logic [3:0]    trig_lvl_i,
  output logic [LW-1:0] fill_o,
  output logic          rx_irq_o,
  output logic          err_irq_o,
  output logic          ovf_o
);
  logic          we, re;
  logic [PW-1:0] wa, ra;

  rx_fifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr_i), .rd_i(rd_i),
    .flush_i(flush_i), .ovf_clr_i(ovf_clr_i), .trig_lvl_i(trig_lvl_i),
    .we_o(we), .wa_o(wa), .re_o(re), .ra_o(ra), .fill_o(fill_o),
    .rx_irq_o(rx_irq_o), .err_irq_o(err_irq_o), .ovf_o(ovf_o)
  );

  rx_fifo_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we), .wa_i(wa), .wd_i(wr_data_i),
    .re_i(re), .ra_i(ra), .rd_o(rd_data_o)
  );
endmodule

// File: tb/rx_fifo_thr_tb.sv
module rx_fifo_thr_tb;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic       wr = 1'b0, rd = 1'b0, flush = 1'b0, clr = 1'b0;
  logic [7:0] wd = '0;
  logic [3:0] trig = '0;
  logic [7:0] rdata;
  logic [3:0] fill;
  logic       rx_irq, err_irq, ovf;

  int n_chk = 0, n_bad = 0;
  byte unsigned mdl[$];
  byte unsigned exp_rd[$];
  byte unsigned last_rd = 0;
  bit           m_ovf = 0;
  bit           done = 0;

  always #10 clk = ~clk;

  rx_fifo_thr u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .wr_data_i(wd), .rd_i(rd),
    .rd_data_o(rdata), .flush_i(flush), .ovf_clr_i(clr), .trig_lvl_i(trig),
    .fill_o(fill), .rx_irq_o(rx_irq), .err_irq_o(err_irq), .ovf_o(ovf)
  );

  task automatic chk(string tag, int act, int exp, string what);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // monitor: compares each read result against the scoreboard
  initial forever begin
    @(posedge clk);
    if (rd && rst_n) begin
      byte unsigned e;
      #5;
      e = exp_rd.pop_front();
      chk("R2", rdata, e, "rd_data");
    end
  end

  // driver: one cycle of stimulus, model update, then output checks
  task automatic step(string tag, bit w, byte unsigned d, bit r, bit f = 0, bit c = 0);
    bit push, pop, ovr;
    int sz;
    bit exp_rx;
    sz   = mdl.size();
    pop  = r && sz > 0 && !f;
    push = w && !f && (sz < 8 || r);
    ovr  = w && !f && sz == 8 && !r;
    if (r) begin
      if (pop) begin last_rd = mdl.pop_front(); end
      exp_rd.push_back(last_rd);
    end
    if (f) mdl.delete();
    if (push) mdl.push_back(d);
    if (ovr) mdl[7] = d;
    exp_rx = ovr || (push && !pop && trig >= 1 && trig <= 8 && mdl.size() == int'(trig));
    if (ovr) m_ovf = 1;
    else if (c) m_ovf = 0;
    wr = w; wd = d; rd = r; flush = f; clr = c;
    @(posedge clk); #5;
    wr = 0; rd = 0; flush = 0; clr = 0;
    chk(tag, fill, mdl.size(), "fill");
    chk(tag, rx_irq, exp_rx, "rx_irq");
    chk(tag, err_irq, ovr, "err_irq");
    chk(tag, ovf, m_ovf, "ovf");
  endtask

  initial begin
    #100000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #5;
    // R1
    chk("R1", fill, 0, "fill"); chk("R1", rdata, 0, "rd_data");
    chk("R1", rx_irq, 0, "rx_irq"); chk("R1", err_irq, 0, "err_irq"); chk("R1", ovf, 0, "ovf");
    rst_n = 1;
    @(posedge clk); #5;
    // R10: empty read after reset returns 0
    step("R10", 0, 0, 1);
    // R4: trigger 3
    trig = 3;
    step("R3", 1, 8'h11, 0);
    step("R3", 1, 8'h22, 0);
    step("R4", 1, 8'h33, 0);
    step("R4", 1, 8'h44, 0);
    for (int i = 0; i < 3; i++) step("R2", 0, 0, 1);
    // R5: two writes back up to 3
    step("R5", 1, 8'h55, 0);
    step("R5", 1, 8'h66, 0);
    for (int i = 0; i < 3; i++) step("R2", 0, 0, 1);
    // R10: empty read holds last byte
    step("R10", 0, 0, 1);
    step("R10", 0, 0, 1);
    // R9: simultaneous write/read at level crossing trig
    trig = 2;
    step("R4", 1, 8'h70, 0);
    step("R9", 1, 8'h71, 1);
    step("R9", 1, 8'h72, 1);
    step("R2", 0, 0, 1);
    // fill to full with trig 8
    trig = 8;
    for (int i = 0; i < 8; i++) step("R3", 1, 8'h80 + 8'(i), 0);
    // R6/R7 overrun
    step("R6", 1, 8'hAA, 0);
    step("R7", 1, 8'hBB, 0);
    step("R8", 0, 0, 0);
    step("R9", 1, 8'hC0, 1);
    // R11: flush keeps ovf
    step("R11", 1, 8'hD0, 1, 1, 0);
    step("R11", 0, 0, 1);
    // R8: clear
    step("R8", 0, 0, 0, 0, 1);
    // R12: trig 0 and 9 never fire
    trig = 0;
    for (int i = 0; i < 8; i++) step("R12", 1, 8'h20 + 8'(i), 0);
    step("R7", 1, 8'hEE, 0, 0, 1);   // overrun wins over clear
    for (int i = 0; i < 8; i++) step("R7", 0, 0, 1);
    step("R8", 0, 0, 0, 0, 1);
    trig = 9;
    for (int i = 0; i < 8; i++) step("R12", 1, 8'h40 + 8'(i), 0);
    step("R11", 0, 0, 0, 1, 0);
    repeat (2) @(posedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule